// File: doc/BRIEF.md
# Pin-or-Register Configuration Source Selector

This block is the control plane that decides where each configuration value of a clock generator comes from. Every function has two possible sources. One is a decoder on the frequency-select strap pins. The other is a small register file written over a serial port. A per-function enable bit in the register file steers a registered mux between the two sources. The block has four parts: a synchronizer and decoder for the strap pins, a mode-0 serial slave with its registers, the function muxes, and a calibrate-command pulse that also fires on pin-driven frequency changes.

One reserved code on the coarse strap field puts the device into serial mode. Register writes are only taken in that mode. The strap decoder holds its last normal decode while the reserved code is present, because the mode pins double as serial pins. A function handed to the registers stays there after the straps return to a normal selection. It goes back to the pins only when software re-enters serial mode and clears its enable bit. Typical use is a board that sets most functions with straps and overrides one divider through a few register writes.

Top module: `cfg_srcsel`

## Requirements
- R1: While `rst` is high, all outputs are 0. After release with straps at zero, the divider outputs show the zero-strap decode (div0 = 1, div1 = 2, div2 = 0).
- R2: With a function's enable clear, the pin decode drives it: div0 = coarse + 1, div1 = fine + 2, div2 = {coarse, fine} (coarse in bits 9:6), drv_mode = mode straps. A strap change reaches the outputs on the 4th rising clock edge after it is applied, and not before.
- R3: Coarse code 4'hF selects serial mode. A write frame arriving when the coarse straps are not 4'hF changes no register.
- R4: A frame is 16 bits, mode 0, MSB first: bit 15 is 1 for a read, bits 14:8 are the address, bits 7:0 are the data. On a read, `spi_miso` carries the addressed register during the last 8 bits, and reads work in any strap mode. Unmapped addresses read 0.
- R5: Register 0x14 bit 2 set routes the registers to the dividers: div0 from 0x15, div1 from 0x16, div2 from {0x18[1:0], 0x17}. The change shows one clock after the write.
- R6: Register 0x14 bit 0 set routes drv_mode from register 0x19 bits 2:0.
- R7: A function whose enable is clear follows the pins even while other functions are register-controlled. While the straps hold 4'hF, pin-controlled values keep their last normal decode.
- R8: Leaving serial mode does not return register-controlled functions to the pins. A write clearing the enable outside serial mode is ignored. Clearing it inside serial mode returns control to the pins.
- R9: Writing register 0x0E with bit 7 and bit 2 both set gives exactly one `vco_cal` cycle. Bit 7 with bit 2 clear gives none. Bit 7 always reads back 0, and bit 2 reads back as written.
- R10: With 0x0E bit 2 clear, a change of the strap selection to a non-reserved code that differs from the last normal one gives exactly one `vco_cal` cycle. With bit 2 set, strap changes give none. Entering serial mode gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_coarse | input | 4 | Coarse frequency-select straps |
| sel_fine | input | 6 | Fine frequency-select straps |
| mode_strap | input | 3 | Output-driver mode straps |
| spi_sclk | input | 1 | Serial clock, oversampled |
| spi_csn | input | 1 | Serial chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial read data, 0 when idle |
| div0_val | output | 8 | Selected first divider value |
| div1_val | output | 8 | Selected second divider value |
| div2_val | output | 10 | Selected third divider value |
| drv_mode | output | 3 | Selected output-driver mode |
| vco_cal | output | 1 | One-cycle calibrate request |

## Verification
A wrong enable bit or a stuck mux select shows up one clock after the write that should have moved it. The divider ports then carry the register value where the strap decode was expected, or the other way round. A missing strap freeze appears four clocks after the reserved code is applied, as a jump to the reserved code's decode. The write gate and the register contents are only visible through readback frames. A bad calibrate gate shows as a wrong count of `vco_cal` cycles within a few clocks of the triggering write or strap change.

// File: rtl/srcsel_pkg.sv
package srcsel_pkg;
  localparam int CRS_W   = 4;
  localparam int FIN_W   = 6;
  localparam int MOD_W   = 3;
  localparam int D0_W    = 8;
  localparam int D1_W    = 8;
  localparam int D2_W    = CRS_W + FIN_W;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int STRAP_W = CRS_W + FIN_W + MOD_W;

  localparam logic [ADDR_W-1:0] ADR_CAL = 7'h0E;
  localparam logic [ADDR_W-1:0] ADR_SRC = 7'h14;
  localparam logic [ADDR_W-1:0] ADR_D0  = 7'h15;
  localparam logic [ADDR_W-1:0] ADR_D1  = 7'h16;
  localparam logic [ADDR_W-1:0] ADR_D2L = 7'h17;
  localparam logic [ADDR_W-1:0] ADR_D2H = 7'h18;
  localparam logic [ADDR_W-1:0] ADR_MOD = 7'h19;

  localparam int CAL_EN_BIT = 2;
  localparam int CAL_GO_BIT = 7;
  localparam int DIV_EN_BIT = 2;
  localparam int MOD_EN_BIT = 0;

  typedef struct packed {
    logic [D2_W-1:0]  d2;
    logic [D1_W-1:0]  d1;
    logic [D0_W-1:0]  d0;
    logic [MOD_W-1:0] md;
  } fval_t;
endpackage

// File: rtl/srcsel_strap.sv
module srcsel_strap
  import srcsel_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CRS_W-1:0]  SER_CODE    = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CRS_W-1:0] sel_coarse,
  input  logic [FIN_W-1:0] sel_fine,
  input  logic [MOD_W-1:0] mode_strap,
  output fval_t            pin_val,
  output logic             pin_chg,
  output logic             ser_mode
);
  logic [SYNC_STAGES-1:0][STRAP_W-1:0] stg;
  logic [CRS_W-1:0]       crs_s;
  logic [FIN_W-1:0]       fin_s;
  logic [MOD_W-1:0]       mod_s;
  logic [CRS_W+FIN_W-1:0] last_sel;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[SYNC_STAGES-2:0], {sel_coarse, sel_fine, mode_strap}};
  end

  assign {crs_s, fin_s, mod_s} = stg[SYNC_STAGES-1];
  assign ser_mode = (crs_s == SER_CODE);

  // decode only on normal codes; hold the last decode while in serial mode
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_val  <= '0;
      pin_chg  <= 1'b0;
      last_sel <= '0;
    end else begin
      pin_chg <= 1'b0;
      if (!ser_mode) begin
        pin_val.d0 <= D0_W'(crs_s) + D0_W'(1);
        pin_val.d1 <= D1_W'(fin_s) + D1_W'(2);
        pin_val.d2 <= {crs_s, fin_s};
        pin_val.md <= mod_s;
        last_sel   <= {crs_s, fin_s};
        pin_chg    <= ({crs_s, fin_s} != last_sel);
      end
    end
  end
endmodule

// File: rtl/srcsel_spi_regs.sv
module srcsel_spi_regs
  import srcsel_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  spi_sclk,
  input  logic  spi_csn,
  input  logic  spi_mosi,
  input  logic  ser_mode,
  output logic  spi_miso,
  output fval_t reg_val,
  output logic  en_div,
  output logic  en_mod,
  output logic  en_cal,
  output logic  cmd_pulse,
  output logic  wr_stb
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [2:0]         sclk_q;
  logic [1:0]         csn_q;
  logic [1:0]         mosi_q;
  logic               rise, fall, cs_act, mosi_s;
  logic [FRAME_W-2:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  tx;
  logic [ADDR_W-1:0]  rd_adr, wr_adr;
  logic [DATA_W-1:0]  wr_dat, rd_dat;
  logic [DATA_W-1:0]  cal_r, src_r, d0_r, d1_r, d2l_r, d2h_r, mod_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      csn_q  <= {csn_q[0], spi_csn};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  assign rise   = sclk_q[1] & ~sclk_q[2];
  assign fall   = ~sclk_q[1] & sclk_q[2];
  assign cs_act = ~csn_q[1];
  assign mosi_s = mosi_q[1];

  assign rd_adr = {sh[ADDR_W-2:0], mosi_s};
  assign wr_adr = sh[FRAME_W-3:DATA_W-1];
  assign wr_dat = {sh[DATA_W-2:0], mosi_s};
  assign wr_stb = rise & cs_act & (cnt == CNT_W'(FRAME_W-1)) & ~sh[FRAME_W-2];

  always_comb begin
    case (rd_adr)
      ADR_CAL: rd_dat = cal_r;
      ADR_SRC: rd_dat = src_r;
      ADR_D0:  rd_dat = d0_r;
      ADR_D1:  rd_dat = d1_r;
      ADR_D2L: rd_dat = d2l_r;
      ADR_D2H: rd_dat = d2h_r;
      ADR_MOD: rd_dat = mod_r;
      default: rd_dat = '0;
    endcase
  end

  // frame shifter and read-data serializer
  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      cnt      <= '0;
      tx       <= '0;
      spi_miso <= 1'b0;
    end else if (!cs_act) begin
      cnt      <= '0;
      spi_miso <= 1'b0;
    end else begin
      if (rise && cnt != CNT_W'(FRAME_W)) begin
        sh  <= {sh[FRAME_W-3:0], mosi_s};
        cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(ADDR_W))
          tx <= sh[ADDR_W-1] ? rd_dat : '0;
      end
      if (fall && cnt >= CNT_W'(ADDR_W + 1)) begin
        spi_miso <= tx[DATA_W-1];
        tx       <= {tx[DATA_W-2:0], 1'b0};
      end
    end
  end

  // register file: writes only in serial mode
  always_ff @(posedge clk) begin
    if (rst) begin
      cal_r <= '0; src_r <= '0; d0_r <= '0; d1_r <= '0;
      d2l_r <= '0; d2h_r <= '0; mod_r <= '0;
      cmd_pulse <= 1'b0;
    end else begin
      cmd_pulse <= 1'b0;
      if (wr_stb && ser_mode) begin
        case (wr_adr)
          ADR_CAL: begin
            cal_r     <= wr_dat & ~(DATA_W'(1) << CAL_GO_BIT);
            cmd_pulse <= wr_dat[CAL_GO_BIT] & wr_dat[CAL_EN_BIT];
          end
          ADR_SRC: src_r <= wr_dat;
          ADR_D0:  d0_r  <= wr_dat;
          ADR_D1:  d1_r  <= wr_dat;
          ADR_D2L: d2l_r <= wr_dat;
          ADR_D2H: d2h_r <= wr_dat;
          ADR_MOD: mod_r <= wr_dat;
          default: ;
        endcase
      end
    end
  end

  assign en_div = src_r[DIV_EN_BIT];
  assign en_mod = src_r[MOD_EN_BIT];
  assign en_cal = cal_r[CAL_EN_BIT];

  assign reg_val.d0 = d0_r;
  assign reg_val.d1 = d1_r;
  assign reg_val.d2 = {d2h_r[D2_W-DATA_W-1:0], d2l_r};
  assign reg_val.md = mod_r[MOD_W-1:0];
endmodule

// File: rtl/srcsel_mux.sv
module srcsel_mux
  import srcsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  fval_t            pin_val,
  input  fval_t            reg_val,
  input  logic             en_div,
  input  logic             en_mod,
  input  logic             en_cal,
  input  logic             cmd_pulse,
  input  logic             pin_chg,
  output logic [D0_W-1:0]  div0_val,
  output logic [D1_W-1:0]  div1_val,
  output logic [D2_W-1:0]  div2_val,
  output logic [MOD_W-1:0] drv_mode,
  output logic             vco_cal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div0_val <= '0;
      div1_val <= '0;
      div2_val <= '0;
      drv_mode <= '0;
      vco_cal  <= 1'b0;
    end else begin
      div0_val <= en_div ? reg_val.d0 : pin_val.d0;
      div1_val <= en_div ? reg_val.d1 : pin_val.d1;
      div2_val <= en_div ? reg_val.d2 : pin_val.d2;
      drv_mode <= en_mod ? reg_val.md : pin_val.md;
      vco_cal  <= cmd_pulse | (pin_chg & ~en_cal);
    end
  end
endmodule

// File: rtl/cfg_srcsel.sv
module cfg_srcsel
  import srcsel_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CRS_W-1:0] SER_CODE    = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CRS_W-1:0] sel_coarse,
  input  logic [FIN_W-1:0] sel_fine,
  input  logic [MOD_W-1:0] mode_strap,
  input  logic             spi_sclk,
  input  logic             spi_csn,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic [D0_W-1:0]  div0_val,
  output logic [D1_W-1:0]  div1_val,
  output logic [D2_W-1:0]  div2_val,
  output logic [MOD_W-1:0] drv_mode,
  output logic             vco_cal
);
  fval_t pin_val, reg_val;
  logic  pin_chg, ser_mode;
  logic  en_div, en_mod, en_cal, cmd_pulse, wr_stb;

  srcsel_strap #(.SYNC_STAGES(SYNC_STAGES), .SER_CODE(SER_CODE)) u_strap (
    .clk(clk), .rst(rst),
    .sel_coarse(sel_coarse), .sel_fine(sel_fine), .mode_strap(mode_strap),
    .pin_val(pin_val), .pin_chg(pin_chg), .ser_mode(ser_mode)
  );

  srcsel_spi_regs u_regs (
    .clk(clk), .rst(rst),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .ser_mode(ser_mode), .spi_miso(spi_miso), .reg_val(reg_val),
    .en_div(en_div), .en_mod(en_mod), .en_cal(en_cal),
    .cmd_pulse(cmd_pulse), .wr_stb(wr_stb)
  );

  srcsel_mux u_mux (
    .clk(clk), .rst(rst),
    .pin_val(pin_val), .reg_val(reg_val),
    .en_div(en_div), .en_mod(en_mod), .en_cal(en_cal),
    .cmd_pulse(cmd_pulse), .pin_chg(pin_chg),
    .div0_val(div0_val), .div1_val(div1_val), .div2_val(div2_val),
    .drv_mode(drv_mode), .vco_cal(vco_cal)
  );
endmodule

// File: rtl/cfg_srcsel_chk.sv
module cfg_srcsel_chk
  import srcsel_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic             ser_mode,
  input logic             en_div,
  input logic             en_mod,
  input fval_t            pin_val,
  input fval_t            reg_val,
  input logic [D0_W-1:0]  div0_val,
  input logic [MOD_W-1:0] drv_mode
);
  // R3
  write_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !ser_mode) |=> $stable(en_div));

  // R5
  div_reg_src_chk: assert property (@(posedge clk) disable iff (rst)
    en_div |=> (div0_val == $past(reg_val.d0)));

  // R7
  div_pin_src_chk: assert property (@(posedge clk) disable iff (rst)
    !en_div |=> (div0_val == $past(pin_val.d0)));

  // R6
  mode_reg_src_chk: assert property (@(posedge clk) disable iff (rst)
    en_mod |=> (drv_mode == $past(reg_val.md)));
endmodule

bind cfg_srcsel cfg_srcsel_chk u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .ser_mode(ser_mode),
  .en_div(en_div), .en_mod(en_mod), .pin_val(pin_val), .reg_val(reg_val),
  .div0_val(div0_val), .drv_mode(drv_mode)
);

// File: tb/tb_cfg_srcsel.sv
module tb_cfg_srcsel;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] crs = '0;
  logic [5:0] fin = '0;
  logic [2:0] mds = '0;
  logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [7:0] d0, d1;
  logic [9:0] d2;
  logic [2:0] md;
  logic       cal;

  int checks = 0;
  int errors = 0;
  int cal_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_srcsel dut (
    .clk(clk), .rst(rst), .sel_coarse(crs), .sel_fine(fin), .mode_strap(mds),
    .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi), .spi_miso(miso),
    .div0_val(d0), .div1_val(d1), .div2_val(d2), .drv_mode(md), .vco_cal(cal)
  );

  always @(negedge clk) if (!rst && cal) cal_cnt++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic pins(input logic [3:0] a, input logic [5:0] y, input logic [2:0] m);
    @(negedge clk);
    crs = a; fin = y; mds = m;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic r, input logic [6:0] adr, input logic [7:0] dat,
                      output logic [7:0] q);
    logic [15:0] fr;
    fr = {r, adr, dat};
    q  = '0;
    @(negedge clk); csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      mosi = fr[i];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      if (i < 8) q[i] = miso;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    csn = 1'b1; mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] adr, input logic [7:0] dat);
    logic [7:0] q;
    xfer(1'b0, adr, dat, q);
  endtask

  task automatic rd(input logic [6:0] adr, output logic [7:0] q);
    xfer(1'b1, adr, 8'h00, q);
  endtask

  task automatic all_out(input string tag, input logic [7:0] e0, input logic [7:0] e1,
                         input logic [9:0] e2, input logic [2:0] em);
    chk({tag, " div0"}, 32'(d0), 32'(e0));
    chk({tag, " div1"}, 32'(d1), 32'(e1));
    chk({tag, " div2"}, 32'(d2), 32'(e2));
    chk({tag, " mode"}, 32'(md), 32'(em));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int c0;
    repeat (4) @(negedge clk);
    // R1 reset state
    all_out("R1 in reset", 8'h0, 8'h0, 10'h0, 3'h0);
    chk("R1 cal in reset", 32'(cal), 0);
    chk("R1 miso in reset", 32'(miso), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    all_out("R1 after reset", 8'd1, 8'd2, 10'd0, 3'd0);

    // R2 latency: change lands on the 4th edge
    crs = 4'd9; fin = 6'd33; mds = 3'd4;
    repeat (3) @(negedge clk);
    chk("R2 latency old div0", 32'(d0), 32'd1);
    @(negedge clk);
    chk("R2 latency new div0", 32'(d0), 32'd10);
    repeat (4) @(negedge clk);

    // R2 decode sweep over normal codes
    for (int a = 0; a < 15; a++) begin
      for (int y = 0; y < 64; y += 5) begin
        pins(4'(a), 6'(y), 3'((a + y) % 8));
        all_out("R2 sweep", 8'(a + 1), 8'(y + 2), 10'(a * 64 + y), 3'((a + y) % 8));
      end
    end

    // R10 pin-driven calibrate pulse
    pins(4'd3, 6'd8, 3'd2);
    c0 = cal_cnt;
    pins(4'd3, 6'd9, 3'd2);
    chk("R10 strap change pulse count", 32'(cal_cnt - c0), 32'd1);

    // R3 writes outside serial mode ignored
    wr(7'h15, 8'hAB);
    wr(7'h14, 8'h04);
    rd(7'h15, q);
    chk("R3 write outside serial ignored", 32'(q), 32'h00);
    all_out("R3 outputs unchanged", 8'd4, 8'd11, 10'h0C9, 3'd2);

    // enter serial mode; pin values freeze, no pulse
    c0 = cal_cnt;
    pins(4'hF, 6'd9, 3'd7);
    chk("R10 no pulse on serial entry", 32'(cal_cnt - c0), 32'd0);
    all_out("R7 frozen decode", 8'd4, 8'd11, 10'h0C9, 3'd2);
    wr(7'h15, 8'hAB);
    wr(7'h16, 8'h5C);
    wr(7'h17, 8'h37);
    wr(7'h18, 8'hFE);
    wr(7'h19, 8'h05);
    rd(7'h15, q);
    chk("R4 readback 0x15", 32'(q), 32'hAB);
    rd(7'h18, q);
    chk("R4 readback 0x18", 32'(q), 32'hFE);
    rd(7'h20, q);
    chk("R4 unmapped reads zero", 32'(q), 32'h00);
    all_out("R7 enables clear", 8'd4, 8'd11, 10'h0C9, 3'd2);

    // R5 dividers to registers, mode stays on pins
    wr(7'h14, 8'h04);
    all_out("R5 dividers from regs", 8'hAB, 8'h5C, 10'h237, 3'd2);
    rd(7'h14, q);
    chk("R4 enable readback", 32'(q), 32'h04);

    // R8 latched after leaving serial mode; R7 mode follows pins
    c0 = cal_cnt;
    pins(4'd5, 6'd1, 3'd6);
    all_out("R8 latched after exit", 8'hAB, 8'h5C, 10'h237, 3'd6);
    chk("R10 pulse on exit to new code", 32'(cal_cnt - c0), 32'd1);
    wr(7'h14, 8'h00);
    all_out("R8 clear outside serial ignored", 8'hAB, 8'h5C, 10'h237, 3'd6);

    // R6 mode from register, dividers back to pins
    pins(4'hF, 6'd1, 3'd0);
    wr(7'h14, 8'h01);
    all_out("R6 mode from reg", 8'd6, 8'd3, 10'h141, 3'd5);

    // R8 full sequence
    wr(7'h14, 8'h05);
    pins(4'd2, 6'd4, 3'd3);
    all_out("R8 both latched", 8'hAB, 8'h5C, 10'h237, 3'd5);
    pins(4'hF, 6'd4, 3'd0);
    wr(7'h14, 8'h00);
    all_out("R8 returned to pins", 8'd3, 8'd6, 10'h084, 3'd3);

    // R9 calibrate command
    c0 = cal_cnt;
    wr(7'h0E, 8'h80);
    chk("R9 no pulse without enable", 32'(cal_cnt - c0), 32'd0);
    c0 = cal_cnt;
    wr(7'h0E, 8'h84);
    chk("R9 single pulse", 32'(cal_cnt - c0), 32'd1);
    rd(7'h0E, q);
    chk("R9 go bit self-clears", 32'(q), 32'h04);

    // R10 pins gated by calibrate enable
    c0 = cal_cnt;
    pins(4'd7, 6'd3, 3'd0);
    chk("R10 no pulse with enable set", 32'(cal_cnt - c0), 32'd0);
    pins(4'hF, 6'd3, 3'd0);
    wr(7'h0E, 8'h00);
    c0 = cal_cnt;
    pins(4'd8, 6'd3, 3'd0);
    chk("R10 pulse with enable clear", 32'(cal_cnt - c0), 32'd1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule